// File: doc/BRIEF.md
# Multi-Queue Write Port with Shared Full Flag

This block is the write side of a four-queue buffer device. Several such devices can be chained, up to eight of them, on a common set of flag lines. A queue-select cycle names a device and a queue on the write address bus. The device whose identifier matches then owns the write side. From the next cycle it drives the shared full flag with the fill state of the chosen queue. Every other device releases the line to high impedance.

Each word is 18 bits wide. A word is taken in on the rising clock edge when the active-low write enable is asserted, provided the owned queue is not full. An accepted word is handed on to queue storage one cycle later, tagged with its queue number. Storage is represented by one occupancy counter per queue. A per-queue decrement input stands in for the read side.

Two configuration pins are captured while master reset is held. One pin selects the default almost-full and almost-empty offset, which is either 8 or 128. The other pin selects serial or default programming.

Top module: `mq_write_port`

## Requirements
- R1: While and just after master reset, the flag drive enable `full_oe` is 0, no queue is owned, and `wq_valid` is 0. Writes are ignored until a matching selection has been made.
- R2: The address field layout is `wr_addr = {device_id, queue}`, with the queue in the low 2 bits. A clock edge with `addr_en` high selects that queue. If the device field equals parameter `DEV_ID`, `full_oe` is 1 from the next cycle. Otherwise `full_oe` is 0 from the next cycle, and `full_n` is high impedance.
- R3: A write is accepted on an edge where `wr_en_n` is 0, the device owns the selection, and the selected queue holds fewer than `DEPTH` words. In the next cycle `wq_valid` is 1, `wq_queue` is the queue number and `wq_data` is the word, and that queue's count rises by one.
- R4: A write attempted while the selected queue is full is ignored. `wq_valid` stays 0 and the count does not change.
- R5: While driven, `full_n` is 0 exactly when the selected queue holds `DEPTH` words. It reflects every write, decrement or new selection from the cycle after the edge.
- R6: A write in the same cycle as a selection goes to the previously selected queue. The new queue takes writes from the next cycle.
- R7: A pulse on `rd_dec[i]` removes one word from queue i. At a count of zero it has no effect.
- R8: `flag_offset` is 8 if `def_off_sel` was 0 during reset, and 128 if it was 1. It stays constant until the next reset.
- R9: `prog_default` is 1 if `def_mode_sel` was 1 during reset, which selects default programming. It is 0 if the pin was 0, which selects serial programming.
- R10: With `wr_en_n` high, nothing is written whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Master reset, active low |
| addr_en | input | 1 | Qualifies a queue selection on `wr_addr` |
| wr_addr | input | 5 | Device identifier (bits 4:2) and queue (bits 1:0) |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Write word |
| rd_dec | input | 4 | Per-queue one-word removal |
| def_off_sel | input | 1 | Offset choice, captured during reset |
| def_mode_sel | input | 1 | Programming-mode choice, captured during reset |
| full_n | output | 1 | Shared full flag, active low, high impedance when not owned |
| full_oe | output | 1 | High while this device drives `full_n` |
| wq_valid | output | 1 | Accepted word present for storage |
| wq_queue | output | 2 | Queue of the accepted word |
| wq_data | output | 18 | Accepted word |
| flag_offset | output | 8 | Almost-full and almost-empty offset |
| prog_default | output | 1 | 1 when default programming is selected |

## Verification
The assertions take for granted that the two configuration pins do not move while reset is held. They also take for granted that `full_n` is only read while `full_oe` is high, because its value when released means nothing. The bench drives the configuration pins only while reset is asserted, and it compares the flag only in cycles where the model expects the device to drive it. The random phase uses both matching and foreign device identifiers, and writes and decrements that collide on the same queue. Every such input pattern stays within these assumptions.

// File: rtl/mq_wp_pkg.sv
package mq_wp_pkg;
    localparam int unsigned MQ_DATA_W   = 18;
    localparam int unsigned MQ_NUM_Q    = 4;
    localparam int unsigned MQ_DEV_ID_W = 3;
    localparam int unsigned MQ_OFF_W    = 8;
    localparam logic [MQ_OFF_W-1:0] MQ_OFF_SMALL = 8'd8;
    localparam logic [MQ_OFF_W-1:0] MQ_OFF_LARGE = 8'd128;

    typedef enum logic {
        PROG_SERIAL  = 1'b0,
        PROG_DEFAULT = 1'b1
    } prog_mode_e;
endpackage

// File: rtl/mq_addr_decode.sv
module mq_addr_decode #(
    parameter int unsigned DEV_ID_W = 3,
    parameter int unsigned QSEL_W   = 2,
    parameter logic [DEV_ID_W-1:0] DEV_ID = '0
) (
    input  logic [DEV_ID_W+QSEL_W-1:0] addr,
    output logic [QSEL_W-1:0]          q_idx,
    output logic                       dev_hit
);
    always_comb begin
        q_idx   = addr[QSEL_W-1:0];
        dev_hit = (addr[DEV_ID_W+QSEL_W-1:QSEL_W] == DEV_ID);
    end
endmodule

// File: rtl/mq_occ_counter.sv
module mq_occ_counter #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full_now,
    output logic full_next
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != LIMIT)) begin
            cnt_d = cnt_d + 1'b1;
        end
        if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_d - 1'b1;
        end
        full_now  = (cnt_q == LIMIT);
        full_next = (cnt_d == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/mq_cfg_capture.sv
module mq_cfg_capture
    import mq_wp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                def_off_sel,
    input  logic                def_mode_sel,
    output logic [MQ_OFF_W-1:0] flag_offset,
    output prog_mode_e          prog_mode
);
    logic [MQ_OFF_W-1:0] off_d, off_q;
    prog_mode_e          mode_d, mode_q;

    // Pins are captured on every clock edge while master reset is held.
    always_comb begin
        off_d  = off_q;
        mode_d = mode_q;
        if (!rst_n) begin
            off_d  = def_off_sel ? MQ_OFF_LARGE : MQ_OFF_SMALL;
            mode_d = def_mode_sel ? PROG_DEFAULT : PROG_SERIAL;
        end
    end

    always_ff @(posedge clk) begin
        off_q  <= off_d;
        mode_q <= mode_d;
    end

    assign flag_offset = off_q;
    assign prog_mode   = mode_q;
endmodule

// File: rtl/mq_write_port.sv
module mq_write_port
    import mq_wp_pkg::*;
#(
    parameter int unsigned DATA_W   = MQ_DATA_W,
    parameter int unsigned NUM_Q    = MQ_NUM_Q,
    parameter int unsigned DEV_ID_W = MQ_DEV_ID_W,
    parameter int unsigned DEPTH    = 16,
    parameter logic [DEV_ID_W-1:0] DEV_ID = 3'd2,
    localparam int unsigned QSEL_W  = $clog2(NUM_Q),
    localparam int unsigned ADDR_W  = DEV_ID_W + QSEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                wr_en_n,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NUM_Q-1:0]    rd_dec,
    input  logic                def_off_sel,
    input  logic                def_mode_sel,
    output logic                full_n,
    output logic                full_oe,
    output logic                wq_valid,
    output logic [QSEL_W-1:0]   wq_queue,
    output logic [DATA_W-1:0]   wq_data,
    output logic [MQ_OFF_W-1:0] flag_offset,
    output logic                prog_default
);
    typedef struct packed {
        logic [QSEL_W-1:0] qsel;
        logic              own;
        logic              full_n;
        logic              wq_valid;
        logic [QSEL_W-1:0] wq_queue;
        logic [DATA_W-1:0] wq_data;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [QSEL_W-1:0] dec_q_idx;
    logic              dec_dev_hit;
    logic [NUM_Q-1:0]  q_inc;
    logic [NUM_Q-1:0]  q_full_now;
    logic [NUM_Q-1:0]  q_full_next;
    logic              accept;
    prog_mode_e        prog_mode;

    mq_addr_decode #(
        .DEV_ID_W (DEV_ID_W),
        .QSEL_W   (QSEL_W),
        .DEV_ID   (DEV_ID)
    ) u_dec (
        .addr    (wr_addr),
        .q_idx   (dec_q_idx),
        .dev_hit (dec_dev_hit)
    );

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_q
        mq_occ_counter #(
            .DEPTH (DEPTH)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (q_inc[gi]),
            .dec       (rd_dec[gi]),
            .full_now  (q_full_now[gi]),
            .full_next (q_full_next[gi])
        );
    end

    mq_cfg_capture u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .def_off_sel  (def_off_sel),
        .def_mode_sel (def_mode_sel),
        .flag_offset  (flag_offset),
        .prog_mode    (prog_mode)
    );

    always_comb begin
        st_d   = st_q;
        // A write always uses the selection held before this edge.
        accept = !wr_en_n && st_q.own && !q_full_now[st_q.qsel];
        q_inc  = '0;
        if (accept) begin
            q_inc[st_q.qsel] = 1'b1;
        end
        st_d.wq_valid = accept;
        st_d.wq_queue = st_q.qsel;
        st_d.wq_data  = accept ? wr_data : st_q.wq_data;
        if (addr_en) begin
            st_d.qsel = dec_q_idx;
            st_d.own  = dec_dev_hit;
        end
        st_d.full_n = !q_full_next[st_d.qsel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{qsel: '0, own: 1'b0, full_n: 1'b1, wq_valid: 1'b0,
                      wq_queue: '0, wq_data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign full_oe      = st_q.own;
    assign full_n       = st_q.own ? st_q.full_n : 1'bz;
    assign wq_valid     = st_q.wq_valid;
    assign wq_queue     = st_q.wq_queue;
    assign wq_data      = st_q.wq_data;
    assign prog_default = (prog_mode == PROG_DEFAULT);
endmodule

// File: rtl/mq_write_port_chk.sv
module mq_write_port_chk #(
    parameter int unsigned DEV_ID_W = 3,
    parameter int unsigned QSEL_W   = 2,
    parameter logic [DEV_ID_W-1:0] DEV_ID = '0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       addr_en,
    input logic [DEV_ID_W+QSEL_W-1:0] wr_addr,
    input logic                       wr_en_n,
    input logic                       full_n,
    input logic                       full_oe,
    input logic                       wq_valid,
    input logic [7:0]                 flag_offset
);
    logic dev_match;
    assign dev_match = (wr_addr[DEV_ID_W+QSEL_W-1:QSEL_W] == DEV_ID);

    p_own_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en && dev_match) |=> full_oe);

    p_release_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en && !dev_match) |=> !full_oe);

    p_write_needs_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_oe && !addr_en) |=> !wq_valid);

    p_no_write_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_oe && !full_n && !wr_en_n) |=> !wq_valid);

    p_idle_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_n |=> !wq_valid);

    p_offset_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_offset == 8'd8) || (flag_offset == 8'd128));

    p_offset_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(flag_offset));
endmodule

bind mq_write_port mq_write_port_chk #(
    .DEV_ID_W (DEV_ID_W),
    .QSEL_W   (QSEL_W),
    .DEV_ID   (DEV_ID)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_en     (addr_en),
    .wr_addr     (wr_addr),
    .wr_en_n     (wr_en_n),
    .full_n      (full_n),
    .full_oe     (full_oe),
    .wq_valid    (wq_valid),
    .flag_offset (flag_offset)
);

// File: tb/sim_mq_write_port.sv
`timescale 1ns/100ps
module sim_mq_write_port;
    localparam int DEPTH = 16;
    localparam logic [2:0] MY_ID = 3'd2;
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic wr_en_n = 1'b1;
    logic [17:0] wr_data = '0;
    logic [3:0] rd_dec = '0;
    logic def_off_sel = 1'b0;
    logic def_mode_sel = 1'b0;
    wire  full_n;
    logic full_oe, wq_valid, prog_default;
    logic [1:0] wq_queue;
    logic [17:0] wq_data;
    logic [7:0] flag_offset;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;
    bit chk_on = 0;

    // reference model state
    int cnt [4];
    int m_sel = 0;
    bit m_own = 0;
    bit exp_oe = 0, exp_full_n = 1, exp_wv = 0;
    int exp_wq = 0;
    logic [17:0] exp_wd = '0;

    always #2.5 clk = ~clk;

    mq_write_port #(.DEPTH(DEPTH), .DEV_ID(MY_ID)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_en(addr_en), .wr_addr(wr_addr),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_dec(rd_dec),
        .def_off_sel(def_off_sel), .def_mode_sel(def_mode_sel),
        .full_n(full_n), .full_oe(full_oe), .wq_valid(wq_valid),
        .wq_queue(wq_queue), .wq_data(wq_data), .flag_offset(flag_offset),
        .prog_default(prog_default)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) cnt[i] = 0;
            m_sel = 0; m_own = 0;
            exp_oe = 0; exp_full_n = 1; exp_wv = 0; exp_wq = 0;
        end else begin
            bit acc;
            int nc [4];
            acc = !wr_en_n && m_own && (cnt[m_sel] < DEPTH);
            exp_wv = acc;
            if (acc) begin exp_wq = m_sel; exp_wd = wr_data; end
            for (int i = 0; i < 4; i++) begin
                nc[i] = cnt[i];
                if (acc && i == m_sel) nc[i]++;
                if (rd_dec[i] && cnt[i] > 0) nc[i]--;
            end
            for (int i = 0; i < 4; i++) cnt[i] = nc[i];
            if (addr_en) begin
                m_sel = int'(wr_addr[1:0]);
                m_own = (wr_addr[4:2] == MY_ID);
            end
            exp_oe = m_own;
            exp_full_n = (cnt[m_sel] != DEPTH);
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R2 full_oe", {31'd0, full_oe}, {31'd0, exp_oe});
            if (exp_oe) chk("R5 full_n", {31'd0, full_n}, {31'd0, exp_full_n});
            chk("R3 wq_valid", {31'd0, wq_valid}, {31'd0, exp_wv});
            if (exp_wv) begin
                chk("R3 wq_queue", {30'd0, wq_queue}, exp_wq);
                chk("R3 wq_data", {14'd0, wq_data}, {14'd0, exp_wd});
            end
        end
    end

    always @(posedge clk) begin
        if (cycles >= WD_LIMIT && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic drive(input bit ae, input logic [2:0] dev, input logic [1:0] q,
                         input bit wen_n, input logic [17:0] d, input logic [3:0] dec);
        @(negedge clk);
        addr_en = ae; wr_addr = {dev, q}; wr_en_n = wen_n; wr_data = d; rd_dec = dec;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(0, 3'd0, 2'd0, 1, 18'h0, 4'h0);
    endtask

    task automatic do_reset(input bit off, input bit mode);
        @(negedge clk);
        rst_n = 0; def_off_sel = off; def_mode_sel = mode;
        addr_en = 0; wr_en_n = 1; rd_dec = 0;
        repeat (4) @(posedge clk);
        chk_on = 1;
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #1;
        chk("R1 full_oe after reset", {31'd0, full_oe}, 32'd0);
        chk("R1 wq_valid after reset", {31'd0, wq_valid}, 32'd0);
        chk("R8 flag_offset", {24'd0, flag_offset}, off ? 32'd128 : 32'd8);
        chk("R9 prog_default", {31'd0, prog_default}, {31'd0, mode});
    endtask

    initial begin
        do_reset(0, 0);
        // R1: write with no selection is ignored
        drive(0, 3'd0, 2'd0, 0, 18'h1111, 4'h0);
        chk("R1 no write before selection", {31'd0, wq_valid}, 32'd0);

        // R7: decrement at zero on queue 0, then fill it exactly
        drive(1, MY_ID, 2'd0, 1, 18'h0, 4'b0001);
        drive(0, 3'd0, 2'd0, 1, 18'h0, 4'b0001);
        chk("R2 owned after selection", {31'd0, full_oe}, 32'd1);
        for (int k = 0; k < DEPTH - 1; k++) drive(0, 3'd0, 2'd0, 0, 18'(k + 16'h100), 4'h0);
        chk("R7 not full at DEPTH-1", {31'd0, full_n}, 32'd1);
        drive(0, 3'd0, 2'd0, 0, 18'h2aaaa, 4'h0);
        chk("R5 full at DEPTH", {31'd0, full_n}, 32'd0);

        // R4: writes while full are ignored, count unchanged
        drive(0, 3'd0, 2'd0, 0, 18'h3ffff, 4'h0);
        chk("R4 no accept when full", {31'd0, wq_valid}, 32'd0);
        drive(0, 3'd0, 2'd0, 0, 18'h3fffe, 4'h0);
        chk("R4 still full", {31'd0, full_n}, 32'd0);
        drive(0, 3'd0, 2'd0, 1, 18'h0, 4'b0001);
        chk("R4 one removal clears full", {31'd0, full_n}, 32'd1);

        // R6: selection and write in the same cycle
        drive(1, MY_ID, 2'd2, 0, 18'h0beef, 4'h0);
        chk("R6 write to previous queue", {30'd0, wq_queue}, 32'd0);
        chk("R6 write accepted", {31'd0, wq_valid}, 32'd1);
        drive(0, 3'd0, 2'd0, 0, 18'h0cafe, 4'h0);
        chk("R6 new queue takes next write", {30'd0, wq_queue}, 32'd2);

        // R2: foreign device releases the flag, writes ignored
        drive(1, 3'd5, 2'd1, 1, 18'h0, 4'h0);
        chk("R2 released on foreign select", {31'd0, full_oe}, 32'd0);
        drive(0, 3'd0, 2'd0, 0, 18'h12345, 4'h0);
        chk("R2 foreign owner blocks write", {31'd0, wq_valid}, 32'd0);

        // R10: enable high with changing data
        drive(1, MY_ID, 2'd3, 1, 18'h0, 4'h0);
        for (int k = 0; k < 4; k++) begin
            drive(0, 3'd0, 2'd0, 1, 18'(k * 18'h1357), 4'h0);
            chk("R10 no write while enable high", {31'd0, wq_valid}, 32'd0);
        end

        // random phase, compared every cycle
        for (int k = 0; k < 600; k++) begin
            bit ae;
            logic [2:0] dev;
            ae  = ($urandom_range(0, 9) == 0);
            dev = ($urandom_range(0, 4) == 0) ? 3'($urandom_range(0, 7)) : MY_ID;
            drive(ae, dev, 2'($urandom_range(0, 3)), ($urandom_range(0, 9) < 4),
                  18'($urandom), 4'($urandom & $urandom));
        end
        idle();

        do_reset(1, 1);
        idle();

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule